// File: doc/BRIEF.md
# Instruction Prefix Modifier Decoder

This block sits in the fetch path of a processor whose register file can be 8, 16, 32 or 64 bits wide. It takes the head bytes of each instruction one at a time, under a single valid qualifier. It recognises up to two optional prefix bytes, the size/offset prefix and the extension prefix, that may come before an opcode. It then hands the opcode forward together with a seven-bit modifier word built from those prefixes. An opcode that arrives without prefixes carries an all-zero modifier word, so legacy 8-bit code runs unchanged. Operand bytes and the second byte of a two-byte opcode are routed elsewhere by the fetch unit. Only the instruction head reaches this decoder.

The size/offset prefix occupies byte values 0xE0 to 0xFF. Its low five bits hold an operand size, an offset-register selector and an addressing-mode flag. The extension prefix occupies byte values 0xD0 to 0xDF. Its low four bits hold a no-zero-extend flag, a user-mode flag and two reserved bits. When both prefixes are present the size/offset prefix must come first. Any other ordering, and any repeated prefix class, is reported as an illegal-sequence abort. The configured core width is an input. An opcode whose size field asks for more than that width is still delivered, and it raises an operand-width abort in the same cycle.

Top module: `pfx_modifier_decoder`

## Requirements
- R1: For a size/offset prefix byte (0xE0–0xFF), payload bits [4:3] become mod_size, bits [2:1] become mod_offset and bit [0] becomes mod_addr_mode on the next delivered opcode.
- R2: For an extension prefix byte (0xD0–0xDF), payload bit [0] becomes mod_no_zext and bit [1] becomes mod_user. Payload bits [3:2] are reserved and have no effect on any output.
- R3: An opcode (any byte outside 0xD0–0xFF) accepted with no prefix before it is delivered with every modifier output zero.
- R4: The accepted order is size/offset prefix, then extension prefix, then opcode, with either prefix optional. An accepted prefix byte produces no output pulse. An accepted opcode byte gives op_valid high for exactly one cycle, in the cycle after it is accepted, with op_code equal to that byte.
- R5: An extension prefix followed by a size/offset prefix, or two prefixes of the same class, pulses abort_illegal in the cycle after the offending byte. No op_valid is produced for that byte. All staged prefixes are discarded.
- R6: Modifiers never carry over: after an opcode is delivered or an abort_illegal occurs, the next opcode sees only its own prefixes. All modifier outputs and base_rel read zero in any cycle where op_valid is low.
- R7: Size and core_width use the encoding 00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 = 64-bit. abort_width pulses together with op_valid exactly when mod_size is greater than the core_width sampled with the opcode byte.
- R8: base_rel is high with op_valid exactly when the offset selector is 11, which selects the base-offset register.
- R9: While rst_n is low, every output is zero. A prefix staged before reset does not affect any opcode accepted after reset.
- R10: byte_data is ignored in cycles where byte_valid is low. Idle cycles between the bytes of one instruction head leave the staged prefixes intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | byte_data holds an instruction-head byte this cycle |
| byte_data | input | 8 | Instruction-head byte |
| core_width | input | 2 | Implemented register width (encoding as in R7) |
| op_valid | output | 1 | One-cycle strobe: opcode delivered |
| op_code | output | 8 | Delivered opcode byte |
| mod_size | output | 2 | Operand size modifier |
| mod_offset | output | 2 | Offset-register selector modifier |
| mod_addr_mode | output | 1 | Addressing-mode modifier |
| mod_no_zext | output | 1 | Suppress zero extension of narrow loads |
| mod_user | output | 1 | Perform access in user mode |
| base_rel | output | 1 | Offset selector picks the base-offset register |
| abort_width | output | 1 | Operand-width abort strobe |
| abort_illegal | output | 1 | Illegal prefix sequence abort strobe |

## Verification
The hardest states to reach from the ports are the recovery paths. One is an illegal prefix sequence arriving while a legal prefix is already staged, after which the next opcode must come out clean. The other is a reset that lands in the middle of an instruction head. The stimulus walks a table of complete heads with fixed orderings, including every illegal pair and a triple that repeats the extension class. Directed sequences then stage a prefix and interrupt it with an illegal byte, with idle gaps, or with reset, before sending a bare opcode. The width abort is reached by changing core_width between heads, so the same size prefix both does and does not exceed the core.

// File: rtl/pfx_dec_pkg.sv
package pfx_dec_pkg;

   localparam int SIZE_W = 2;
   localparam int OFS_W  = 2;

   typedef struct packed {
      logic [SIZE_W-1:0] size;
      logic [OFS_W-1:0]  ofs;
      logic              am;
      logic              nze;
      logic              user;
   } mod_t;

   localparam mod_t MOD_NONE = '0;

   typedef enum logic [1:0] {
      CLS_OPCODE = 2'd0,
      CLS_SIZE   = 2'd1,
      CLS_EXT    = 2'd2
   } byte_cls_t;

   typedef enum logic [1:0] {
      ST_EMPTY    = 2'd0,
      ST_HAVE_SZ  = 2'd1,
      ST_HAVE_EXT = 2'd2
   } seq_state_t;

endpackage

// File: rtl/pfx_byte_class.sv
module pfx_byte_class
   import pfx_dec_pkg::*;
#(
   parameter int             BYTE_W    = 8,
   parameter logic [BYTE_W-1:0] SZ_BASE = 8'hE0,
   parameter int             SZ_PAY_W  = 5,
   parameter logic [BYTE_W-1:0] EXT_BASE = 8'hD0,
   parameter int             EXT_PAY_W = 4,
   parameter int             SZ_SIZE_LSB = 3,
   parameter int             SZ_OFS_LSB  = 1,
   parameter int             SZ_AM_BIT   = 0,
   parameter int             EXT_NZE_BIT = 0,
   parameter int             EXT_USR_BIT = 1
) (
   input  logic [BYTE_W-1:0] byte_in,
   output byte_cls_t         cls,
   output mod_t              sz_fields,
   output mod_t              ext_fields
);

   localparam int SZ_TAG_W  = BYTE_W - SZ_PAY_W;
   localparam int EXT_TAG_W = BYTE_W - EXT_PAY_W;

   logic [SZ_TAG_W-1:0]  sz_tag;
   logic [EXT_TAG_W-1:0] ext_tag;
   logic [SZ_PAY_W-1:0]  sz_pay;
   logic [EXT_PAY_W-1:0] ext_pay;
   logic                 hit_sz;
   logic                 hit_ext;

   assign sz_tag  = byte_in[BYTE_W-1:SZ_PAY_W];
   assign ext_tag = byte_in[BYTE_W-1:EXT_PAY_W];
   assign sz_pay  = byte_in[SZ_PAY_W-1:0];
   assign ext_pay = byte_in[EXT_PAY_W-1:0];

   assign hit_sz  = (sz_tag  == SZ_BASE[BYTE_W-1:SZ_PAY_W]);
   assign hit_ext = (ext_tag == EXT_BASE[BYTE_W-1:EXT_PAY_W]);

   always_comb begin
      if (hit_sz)
         cls = CLS_SIZE;
      else if (hit_ext)
         cls = CLS_EXT;
      else
         cls = CLS_OPCODE;
   end

   always_comb begin
      sz_fields      = MOD_NONE;
      sz_fields.size = sz_pay[SZ_SIZE_LSB +: SIZE_W];
      sz_fields.ofs  = sz_pay[SZ_OFS_LSB +: OFS_W];
      sz_fields.am   = sz_pay[SZ_AM_BIT];
   end

   always_comb begin
      ext_fields      = MOD_NONE;
      ext_fields.nze  = ext_pay[EXT_NZE_BIT];
      ext_fields.user = ext_pay[EXT_USR_BIT];
   end

endmodule

// File: rtl/pfx_order_fsm.sv
module pfx_order_fsm
   import pfx_dec_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      in_valid,
   input  byte_cls_t cls,
   output logic      load_sz,
   output logic      load_ext,
   output logic      deliver,
   output logic      illegal
);

   seq_state_t state_q;
   seq_state_t state_d;

   always_comb begin
      state_d  = state_q;
      load_sz  = 1'b0;
      load_ext = 1'b0;
      deliver  = 1'b0;
      illegal  = 1'b0;
      if (in_valid) begin
         unique case (cls)
            CLS_OPCODE: begin
               deliver = 1'b1;
               state_d = ST_EMPTY;
            end
            CLS_SIZE: begin
               if (state_q == ST_EMPTY) begin
                  load_sz = 1'b1;
                  state_d = ST_HAVE_SZ;
               end else begin
                  illegal = 1'b1;
                  state_d = ST_EMPTY;
               end
            end
            CLS_EXT: begin
               if (state_q != ST_HAVE_EXT) begin
                  load_ext = 1'b1;
                  state_d  = ST_HAVE_EXT;
               end else begin
                  illegal = 1'b1;
                  state_d = ST_EMPTY;
               end
            end
            default: begin
               illegal = 1'b1;
               state_d = ST_EMPTY;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         state_q <= ST_EMPTY;
      else
         state_q <= state_d;
   end

endmodule

// File: rtl/pfx_mod_stage.sv
module pfx_mod_stage
   import pfx_dec_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load_sz,
   input  logic load_ext,
   input  logic flush,
   input  mod_t sz_fields,
   input  mod_t ext_fields,
   output mod_t staged
);

   mod_t staged_q;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         staged_q <= MOD_NONE;
      end else begin
         if (load_sz) begin
            staged_q.size <= sz_fields.size;
            staged_q.ofs  <= sz_fields.ofs;
            staged_q.am   <= sz_fields.am;
         end
         if (load_ext) begin
            staged_q.nze  <= ext_fields.nze;
            staged_q.user <= ext_fields.user;
         end
      end
   end

   assign staged = staged_q;

endmodule

// File: rtl/pfx_width_guard.sv
module pfx_width_guard
   import pfx_dec_pkg::*;
#(
   parameter bit CHECK_EN = 1'b1
) (
   input  logic [SIZE_W-1:0] req_size,
   input  logic [SIZE_W-1:0] core_size,
   output logic              too_wide
);

   generate
      if (CHECK_EN) begin : g_cmp
         assign too_wide = (req_size > core_size);
      end else begin : g_off
         logic unused_ok;
         assign unused_ok = ^{req_size, core_size};
         assign too_wide  = 1'b0 & unused_ok;
      end
   endgenerate

endmodule

// File: rtl/pfx_modifier_decoder.sv
module pfx_modifier_decoder
   import pfx_dec_pkg::*;
#(
   parameter int                BYTE_W      = 8,
   parameter logic [BYTE_W-1:0] SZ_BASE     = 8'hE0,
   parameter int                SZ_PAY_W    = 5,
   parameter logic [BYTE_W-1:0] EXT_BASE    = 8'hD0,
   parameter int                EXT_PAY_W   = 4,
   parameter logic [1:0]        BASE_OFS_SEL = 2'b11,
   parameter bit                WIDTH_ABORT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_data,
   input  logic [1:0]        core_width,
   output logic              op_valid,
   output logic [BYTE_W-1:0] op_code,
   output logic [1:0]        mod_size,
   output logic [1:0]        mod_offset,
   output logic              mod_addr_mode,
   output logic              mod_no_zext,
   output logic              mod_user,
   output logic              base_rel,
   output logic              abort_width,
   output logic              abort_illegal
);

   localparam int SZ_FIELD_BITS  = SIZE_W + OFS_W + 1;
   localparam int EXT_FIELD_BITS = 2;

   generate
      if (SZ_PAY_W < SZ_FIELD_BITS) begin : g_bad_sz_pay
         $error("size prefix payload too narrow for its fields");
      end
      if (EXT_PAY_W < EXT_FIELD_BITS) begin : g_bad_ext_pay
         $error("extension prefix payload too narrow for its fields");
      end
      if (SZ_PAY_W >= BYTE_W || EXT_PAY_W >= BYTE_W) begin : g_bad_tag
         $error("prefix classes need at least one tag bit");
      end
      if (SZ_BASE[BYTE_W-1:EXT_PAY_W] == EXT_BASE[BYTE_W-1:EXT_PAY_W]) begin : g_bad_overlap
         $error("prefix byte ranges overlap");
      end
   endgenerate

   byte_cls_t cls;
   mod_t      sz_fields;
   mod_t      ext_fields;
   mod_t      staged;
   logic      load_sz;
   logic      load_ext;
   logic      deliver;
   logic      illegal;
   logic      too_wide;

   pfx_byte_class #(
      .BYTE_W   (BYTE_W),
      .SZ_BASE  (SZ_BASE),
      .SZ_PAY_W (SZ_PAY_W),
      .EXT_BASE (EXT_BASE),
      .EXT_PAY_W(EXT_PAY_W)
   ) u_class (
      .byte_in   (byte_data),
      .cls       (cls),
      .sz_fields (sz_fields),
      .ext_fields(ext_fields)
   );

   pfx_order_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_valid(byte_valid),
      .cls     (cls),
      .load_sz (load_sz),
      .load_ext(load_ext),
      .deliver (deliver),
      .illegal (illegal)
   );

   pfx_mod_stage u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_sz   (load_sz),
      .load_ext  (load_ext),
      .flush     (deliver | illegal),
      .sz_fields (sz_fields),
      .ext_fields(ext_fields),
      .staged    (staged)
   );

   pfx_width_guard #(
      .CHECK_EN(WIDTH_ABORT_EN)
   ) u_width (
      .req_size (staged.size),
      .core_size(core_width),
      .too_wide (too_wide)
   );

   logic              op_valid_q;
   logic [BYTE_W-1:0] op_code_q;
   mod_t              mods_q;
   logic              base_q;
   logic              abort_w_q;
   logic              abort_i_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_valid_q <= 1'b0;
         op_code_q  <= '0;
         mods_q     <= MOD_NONE;
         base_q     <= 1'b0;
         abort_w_q  <= 1'b0;
         abort_i_q  <= 1'b0;
      end else begin
         op_valid_q <= deliver;
         op_code_q  <= deliver ? byte_data : '0;
         mods_q     <= deliver ? staged : MOD_NONE;
         base_q     <= deliver && (staged.ofs == BASE_OFS_SEL);
         abort_w_q  <= deliver && too_wide;
         abort_i_q  <= illegal;
      end
   end

   assign op_valid      = op_valid_q;
   assign op_code       = op_code_q;
   assign mod_size      = mods_q.size;
   assign mod_offset    = mods_q.ofs;
   assign mod_addr_mode = mods_q.am;
   assign mod_no_zext   = mods_q.nze;
   assign mod_user      = mods_q.user;
   assign base_rel      = base_q;
   assign abort_width   = abort_w_q;
   assign abort_illegal = abort_i_q;

endmodule

// File: rtl/pfx_modifier_decoder_chk.sv
module pfx_modifier_decoder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       byte_valid,
   input logic [7:0] byte_data,
   input logic [1:0] core_width,
   input logic       op_valid,
   input logic [7:0] op_code,
   input logic [1:0] mod_size,
   input logic [1:0] mod_offset,
   input logic       mod_addr_mode,
   input logic       mod_no_zext,
   input logic       mod_user,
   input logic       base_rel,
   input logic       abort_width,
   input logic       abort_illegal
);

   function automatic logic is_prefix(input logic [7:0] b);
      return (b[7:5] == 3'b111) || (b[7:4] == 4'hD);
   endfunction

   assert_prefix_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid && is_prefix(byte_data) |=> !op_valid);

   assert_opcode_not_prefix_R4: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> !is_prefix(op_code));

   assert_output_needs_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid || abort_illegal) |-> $past(byte_valid));

   assert_illegal_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      abort_illegal |-> !op_valid && is_prefix($past(byte_data)));

   assert_mods_zero_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> (mod_size == 2'b00) && (mod_offset == 2'b00) && !mod_addr_mode
                    && !mod_no_zext && !mod_user && !base_rel && !abort_width);

   assert_width_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> (abort_width == (mod_size > $past(core_width))));

   assert_base_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> (base_rel == (mod_offset == 2'b11)));

   assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !op_valid && !abort_illegal && !abort_width);

endmodule

bind pfx_modifier_decoder pfx_modifier_decoder_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .byte_valid   (byte_valid),
   .byte_data    (byte_data),
   .core_width   (core_width),
   .op_valid     (op_valid),
   .op_code      (op_code),
   .mod_size     (mod_size),
   .mod_offset   (mod_offset),
   .mod_addr_mode(mod_addr_mode),
   .mod_no_zext  (mod_no_zext),
   .mod_user     (mod_user),
   .base_rel     (base_rel),
   .abort_width  (abort_width),
   .abort_illegal(abort_illegal)
);

// File: tb/pfx_modifier_decoder_bench.sv
`timescale 1ns/1ps
module pfx_modifier_decoder_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       byte_valid = 1'b0;
   logic [7:0] byte_data = 8'h00;
   logic [1:0] core_width = 2'b11;
   logic       op_valid;
   logic [7:0] op_code;
   logic [1:0] mod_size;
   logic [1:0] mod_offset;
   logic       mod_addr_mode;
   logic       mod_no_zext;
   logic       mod_user;
   logic       base_rel;
   logic       abort_width;
   logic       abort_illegal;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   pfx_modifier_decoder u_pfx_modifier_decoder (
      .clk          (clk),
      .rst_n        (rst_n),
      .byte_valid   (byte_valid),
      .byte_data    (byte_data),
      .core_width   (core_width),
      .op_valid     (op_valid),
      .op_code      (op_code),
      .mod_size     (mod_size),
      .mod_offset   (mod_offset),
      .mod_addr_mode(mod_addr_mode),
      .mod_no_zext  (mod_no_zext),
      .mod_user     (mod_user),
      .base_rel     (base_rel),
      .abort_width  (abort_width),
      .abort_illegal(abort_illegal)
   );

   // mods packing: {size[1:0], offset[1:0], addr_mode, no_zext, user}
   typedef struct packed {
      logic [2:0]  n;
      logic [31:0] bytes;
      logic [1:0]  cw;
      logic [7:0]  op;
      logic [6:0]  mods;
      logic        ev;
      logic        aw;
      logic        ai;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{3'd1, 32'hA9000000, 2'b11, 8'hA9, 7'b0000000, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 bare
      '{3'd2, 32'hE8A90000, 2'b11, 8'hA9, 7'b0100000, 1'b1, 1'b0, 1'b0, 4'd1},  // R1 size
      '{3'd2, 32'hE6AD0000, 2'b11, 8'hAD, 7'b0011000, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 base
      '{3'd2, 32'hE1AD0000, 2'b11, 8'hAD, 7'b0000100, 1'b1, 1'b0, 1'b0, 4'd1},  // R1 am
      '{3'd2, 32'hD38D0000, 2'b11, 8'h8D, 7'b0000011, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 flags
      '{3'd2, 32'hDC8D0000, 2'b11, 8'h8D, 7'b0000000, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 reserved
      '{3'd3, 32'hF5D18500, 2'b11, 8'h85, 7'b1010110, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 both
      '{3'd3, 32'hF8D0A900, 2'b01, 8'hA9, 7'b1100000, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 over
      '{3'd2, 32'hF0A90000, 2'b10, 8'hA9, 7'b1000000, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 equal
      '{3'd2, 32'hE8A90000, 2'b00, 8'hA9, 7'b0100000, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 8-bit core
      '{3'd2, 32'hD2E00000, 2'b11, 8'h00, 7'b0000000, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 order
      '{3'd2, 32'hE0E40000, 2'b11, 8'h00, 7'b0000000, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 repeat
      '{3'd3, 32'hE0D0D100, 2'b11, 8'h00, 7'b0000000, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 repeat ext
      '{3'd3, 32'hE0D0E000, 2'b11, 8'h00, 7'b0000000, 1'b0, 1'b0, 1'b1, 4'd5}   // R5 late size
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b);
      byte_valid = 1'b1;
      byte_data  = b;
      @(negedge clk);
      byte_valid = 1'b0;
      byte_data  = 8'h5A;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic logic [6:0] mods_now();
      return {mod_size, mod_offset, mod_addr_mode, mod_no_zext, mod_user};
   endfunction

   task automatic expect_op(input string req, input logic [7:0] op, input logic [6:0] m);
      chk({req, " op_valid"}, 32'(op_valid), 32'd1);
      chk({req, " op_code"}, 32'(op_code), 32'(op));
      chk({req, " mods"}, 32'(mods_now()), 32'(m));
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL R4 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      idle(3);
      // R9: outputs zero during reset
      chk("R9 reset op_valid", 32'(op_valid), 32'd0);
      chk("R9 reset mods", 32'(mods_now()), 32'd0);
      chk("R9 reset aborts", 32'({abort_width, abort_illegal, base_rel}), 32'd0);
      rst_n = 1'b1;
      idle(1);

      for (int i = 0; i < NV; i++) begin
         string tg;
         tg = $sformatf("R%0d vec%0d", VEC[i].rq, i);
         core_width = VEC[i].cw;
         for (int k = 0; k < int'(VEC[i].n); k++) begin
            put(VEC[i].bytes[31 - 8*k -: 8]);
            if (k < int'(VEC[i].n) - 1)
               chk({tg, " R4 prefix quiet"}, 32'({op_valid, abort_illegal}), 32'd0);
         end
         chk({tg, " op_valid"}, 32'(op_valid), 32'(VEC[i].ev));
         chk({tg, " abort_width"}, 32'(abort_width), 32'(VEC[i].aw));
         chk({tg, " abort_illegal"}, 32'(abort_illegal), 32'(VEC[i].ai));
         if (VEC[i].ev) begin
            chk({tg, " op_code"}, 32'(op_code), 32'(VEC[i].op));
            chk({tg, " mods"}, 32'(mods_now()), 32'(VEC[i].mods));
            chk({tg, " R8 base_rel"}, 32'(base_rel), 32'(VEC[i].mods[4:3] == 2'b11));
         end
         idle(1);
         chk({tg, " R4 single pulse"}, 32'({op_valid, abort_illegal, abort_width}), 32'd0);
      end

      // R5 then R6: staged prefix discarded after illegal, next opcode clean
      core_width = 2'b11;
      put(8'hD3);
      put(8'hE8);
      chk("R5 illegal after staged ext", 32'(abort_illegal), 32'd1);
      put(8'hA9);
      expect_op("R6 clean after abort", 8'hA9, 7'b0000000);

      // R6: no carry-over from a prefixed opcode
      put(8'hF7);
      put(8'hD3);
      put(8'h4C);
      expect_op("R6 prefixed op", 8'h4C, 7'b1011111);
      put(8'h4C);
      expect_op("R6 next op bare", 8'h4C, 7'b0000000);

      // R10: gaps keep staged prefixes; ignored data while invalid
      put(8'hE8);
      byte_data = 8'hE1;
      idle(4);
      chk("R10 gap quiet", 32'({op_valid, abort_illegal}), 32'd0);
      put(8'hD1);
      byte_data = 8'hD2;
      idle(3);
      put(8'hA9);
      expect_op("R10 gap result", 8'hA9, 7'b0100010);

      // R9: reset mid-prefix discards it
      put(8'hFF);
      rst_n = 1'b0;
      idle(2);
      chk("R9 in reset", 32'({op_valid, abort_illegal, abort_width}), 32'd0);
      rst_n = 1'b1;
      idle(1);
      core_width = 2'b00;
      put(8'hA9);
      expect_op("R9 after reset", 8'hA9, 7'b0000000);
      chk("R9 R7 no width abort", 32'(abort_width), 32'd0);

      idle(2);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule